// File: doc/BRIEF.md
# Elastic Sample Slip Regenerator

This block sits behind a timing error detector in an oversampled burst receiver. It rewrites the incoming sample stream so that the symbol rate matches the local clock. Samples enter at one per clock and pass through a tapped delay line. The output is taken from a tap that moves by one position for each accepted correction. A shortage request moves the tap one step older, so one sample appears twice and every later sample is one slot late. A surplus request moves the tap one step newer, so one sample is skipped and every later sample is one slot early.

The tap offset is signed and centred on the middle of the line. It therefore records the net slip accumulated since the burst began. The line depth limits how far the offset can travel. A request that would push the offset past either end is refused and raises a sticky overflow flag. The correction is feed-forward and its latency is fixed. A burst start pulse empties the line and re-centres the offset. When correction is disabled, the block acts as a fixed delay and ignores all requests.

Top module: `sample_slip_regen`

## Requirements
- R1: After reset, or in the cycle after a burst start pulse, the output is zero, the overflow flag is low and the offset is centred. The sample presented during a burst start cycle is discarded.
- R2: With correction enabled, no requests and a centred offset, a sample presented before clock edge k appears on the output after edge k+C. C = (DEPTH-1)/2, which is 4 for DEPTH 9.
- R3: An accepted shortage request (add high, drop low, enable high) moves the offset one slot older. The output after that edge repeats the previous output, and all later samples are delayed by one extra slot.
- R4: An accepted surplus request (drop high, add low, enable high) moves the offset one slot newer. One sample is skipped, and all later samples are advanced by one slot.
- R5: The offset stays within -C..+C. A request that would go past either limit is refused and leaves the stream unchanged.
- R6: Add and drop asserted in the same cycle cancel each other. The offset and the stream timing are unchanged.
- R7: With enable low, the output is taken from the centre tap, with latency C+1 edges. Requests are ignored and the offset is kept, so it takes effect again once enable returns.
- R8: Alternating shortage and surplus requests are each applied in turn. After an equal number of each, the stream returns to nominal latency.
- R9: A refused request sets the overflow flag in the cycle after it. The flag stays high until reset or a burst start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | Clears the delay line, the offset and the overflow flag |
| slip_en | input | 1 | High: apply corrections; low: fixed centre-tap delay |
| in_data | input | W | Incoming oversampled sample |
| add_req | input | 1 | Shortage request: duplicate one sample |
| drop_req | input | 1 | Surplus request: remove one sample |
| out_data | output | W | Regenerated sample stream |
| slip_ovf | output | 1 | Sticky flag for a refused request |

## Verification
The assertions assume that rst_n is synchronous and held for at least one edge. They also assume that the enable and request inputs are settled before each edge. The duplicate-sample property allows enable to change in the following cycle. The bench drives every input on the falling edge and never changes anything close to a rising edge. It pulses burst_start often enough that its reference history never runs past its own array.

// File: rtl/sample_slip_regen.sv
module sample_slip_regen #(
  parameter int W     = 8,
  parameter int DEPTH = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         burst_start,
  input  logic         slip_en,
  input  logic [W-1:0] in_data,
  input  logic         add_req,
  input  logic         drop_req,
  output logic [W-1:0] out_data,
  output logic         slip_ovf
);
  localparam int C  = (DEPTH - 1) / 2;
  localparam int OW = $clog2(DEPTH) + 1;
  localparam int TW = $clog2(DEPTH);
  localparam logic signed [OW-1:0] OMAX = OW'(C);
  localparam logic signed [OW-1:0] OMIN = -OW'(C);

  logic [W-1:0]          line [DEPTH];
  logic signed [OW-1:0]  off;
  logic [TW-1:0]         tap;

  wire net_add  = slip_en & add_req & ~drop_req;
  wire net_drop = slip_en & drop_req & ~add_req;
  wire add_room  = (off != OMAX);
  wire drop_room = (off != OMIN);

  always_ff @(posedge clk) begin
    if (!rst_n || burst_start) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
      off      <= '0;
      slip_ovf <= 1'b0;
    end else begin
      line[0] <= in_data;
      for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
      if (net_add) begin
        if (add_room) off <= off + 1'b1;
        else          slip_ovf <= 1'b1;
      end else if (net_drop) begin
        if (drop_room) off <= off - 1'b1;
        else           slip_ovf <= 1'b1;
      end
    end
  end

  always_comb tap = slip_en ? TW'(C + int'(off)) : TW'(C);
  assign out_data = line[tap];

  // R1
  clear_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (out_data == '0 && !slip_ovf));

  // R3
  dup_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_en && add_req && !drop_req && !burst_start && off != OMAX)
      |=> (!slip_en || $stable(out_data)));

  // R5
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off >= OMIN && off <= OMAX));

  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_req && drop_req && !burst_start) |=> $stable(off));

  // R7
  bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slip_en && !burst_start) |=> $stable(off));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_en && add_req && !drop_req && !burst_start && off == OMAX) |=> slip_ovf);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_ovf && !burst_start) |=> slip_ovf);
endmodule

// File: tb/test_sample_slip_regen.sv
module test_sample_slip_regen;
  localparam int PERIOD = 10;
  localparam int W = 8;
  localparam int DEPTH = 9;
  localparam int C = (DEPTH - 1) / 2;

  logic clk = 0, rst_n = 0, burst_start = 0, slip_en = 0, add_req = 0, drop_req = 0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] out_data;
  logic slip_ovf;

  int vectors = 0, errors = 0;
  int hist [8192];
  int cnt = 0, moff = 0;
  bit mofv = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(PERIOD/2) clk = ~clk;

  sample_slip_regen #(.W(W), .DEPTH(DEPTH)) i_sample_slip_regen (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .slip_en(slip_en),
    .in_data(in_data), .add_req(add_req), .drop_req(drop_req),
    .out_data(out_data), .slip_ovf(slip_ovf));

  task automatic compare(input string tag, input logic e);
    int tap, idx, exp_d;
    tap = e ? C + moff : C;
    idx = cnt - 1 - tap;
    exp_d = (idx < 0) ? 0 : hist[idx];
    vectors++;
    if (out_data !== W'(exp_d) || slip_ovf !== mofv) begin
      errors++;
      $display("FAIL %s: out=%0d ovf=%0b expected out=%0d ovf=%0b",
               tag, out_data, slip_ovf, exp_d, mofv);
    end
  endtask

  task automatic step(input int d, input logic a, input logic dr,
                      input logic e, input logic bs, input string tag);
    in_data = W'(d); add_req = a; drop_req = dr; slip_en = e; burst_start = bs;
    @(posedge clk);
    if (bs) begin
      cnt = 0; moff = 0; mofv = 0;
    end else begin
      hist[cnt] = d & 8'hFF; cnt++;
      if (e && a && !dr) begin
        if (moff < C) moff++; else mofv = 1;
      end else if (e && dr && !a) begin
        if (moff > -C) moff--; else mofv = 1;
      end
    end
    @(negedge clk);
    compare(tag, e);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int seq;
    seq = 1;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare("R1 reset", 1'b0);
    rst_n = 1;
    for (int i = 0; i < 12; i++) step(seq++, 0, 0, 1, 0, "R2 latency");
    step(seq++, 1, 0, 1, 0, "R3 insert");
    for (int i = 0; i < 6; i++) step(seq++, 0, 0, 1, 0, "R3 after insert");
    step(seq++, 0, 1, 1, 0, "R4 delete");
    step(seq++, 0, 1, 1, 0, "R4 delete");
    for (int i = 0; i < 6; i++) step(seq++, 0, 0, 1, 0, "R4 after delete");
    for (int i = 0; i < 7; i++) step(seq++, 1, 0, 1, 0, "R5 upper limit");
    for (int i = 0; i < 4; i++) step(seq++, 0, 0, 1, 0, "R9 sticky");
    step(seq++, 0, 0, 1, 1, "R1 burst start");
    for (int i = 0; i < 7; i++) step(seq++, 0, 0, 1, 0, "R1 refill");
    for (int i = 0; i < 6; i++) step(seq++, 0, 1, 1, 0, "R5 lower limit");
    for (int i = 0; i < 4; i++) step(seq++, 0, 0, 1, 0, "R9 sticky");
    step(seq++, 0, 0, 1, 1, "R1 burst start");
    for (int i = 0; i < 6; i++) step(seq++, 1, 1, 1, 0, "R6 cancel");
    for (int i = 0; i < 20; i++) step(seq++, (i % 2) == 0, (i % 2) == 1, 1, 0, "R8 alternate");
    for (int i = 0; i < 6; i++) step(seq++, 0, 0, 1, 0, "R8 nominal");
    step(seq++, 1, 0, 1, 0, "R3 insert");
    for (int i = 0; i < 10; i++) step(seq++, i[0], i[1], 0, 0, "R7 bypass");
    for (int i = 0; i < 6; i++) step(seq++, 0, 0, 1, 0, "R7 offset kept");
    step(seq++, 0, 0, 1, 1, "R1 burst start");
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[15:8]), lfsr[0], lfsr[1], lfsr[3:2] != 2'b00,
           lfsr[7:2] == 6'd0, "sweep R3 R4 R5 R6 R7 R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule